// File: doc/BRIEF.md
# DRAM Refresh Debt Tracker

This block tracks how many refreshes one DRAM channel owes. An interval timer runs from a programmable period and ticks once per period. Each tick adds one to an owed count, which saturates. While the count is non-zero and refresh issue is enabled, the block asks the command scheduler for a refresh. Each accepted acknowledge retires one owed refresh. When the count builds up, an urgency flag lets the scheduler put refresh ahead of other traffic.

Two enable inputs select the mode. With issue enabled, the timer always runs, whatever the other input says. With issue off and counting on, the block banks owed refreshes but does not request them. With both off, the block is idle. While the DRAM is in self-refresh, the timer is frozen and the owed count is cleared, because the device refreshes itself during that time. On leaving self-refresh, a 2-bit bonus code adds 0 to 3 extra refreshes to the count. No request is raised until a programmable settling wait has elapsed; 255 cycles is the recommended setting.

Top module: `refresh_owed_ctrl`

## Requirements
- R1: After reset, `owed` is 0 and `ref_req` and `ref_urgent` are low.
- R2: While the timer runs, it ticks once every `cfg_period` running cycles, and `cfg_period` = 0 behaves as 1. Each tick adds one to `owed`. The timer runs when `cfg_ref_en` or `cfg_cnt_en` is high and `sr_active` is low.
- R3: With `cfg_ref_en` high, `ref_req` is high exactly when `owed` is non-zero, `sr_active` is low and the exit wait has expired. This holds whatever the value of `cfg_cnt_en`.
- R4: With `cfg_ref_en` low and `cfg_cnt_en` high, `owed` keeps growing from ticks while `ref_req` stays low, and `ref_ack` is ignored.
- R5: With both `cfg_ref_en` and `cfg_cnt_en` low, no tick occurs and `owed` does not change outside self-refresh.
- R6: `owed` never exceeds 8. A tick at 8 leaves it at 8.
- R7: `ref_urgent` is high exactly when `owed` is 6 or more.
- R8: An edge with both `ref_ack` and `ref_req` high lowers `owed` by one. An `ref_ack` while `ref_req` is low has no effect.
- R9: A tick and an accepted acknowledge on the same edge leave `owed` unchanged.
- R10: At each edge where `sr_active` is high, `owed` is cleared and the timer holds its value. `ref_req` is low while `sr_active` is high.
- R11: At the first edge after `sr_active` falls, `owed` gains the bonus given by `cfg_exit_bonus` (00→0, 01→1, 10→2, 11→3), plus any tick at that edge. The bonus is added only when `cfg_ref_en` or `cfg_cnt_en` is high.
- R12: After `sr_active` falls, `ref_req` stays low for `cfg_exit_wait` clock edges and may rise after the edge that ends that wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ref_en | input | 1 | Refresh issue enable |
| cfg_cnt_en | input | 1 | Count-only enable (used when issue is off) |
| cfg_period | input | PERIOD_W | Timer period in cycles (0 treated as 1) |
| cfg_exit_bonus | input | 2 | Extra refreshes owed on self-refresh exit |
| cfg_exit_wait | input | WAIT_W | Cycles to hold off requests after self-refresh exit |
| sr_active | input | 1 | DRAM is in self-refresh |
| ref_ack | input | 1 | Scheduler accepted one refresh |
| ref_req | output | 1 | Refresh request to the scheduler |
| ref_urgent | output | 1 | Owed count is at or above the urgency level |
| owed | output | CW | Current owed refresh count |

## Verification
`owed` and `ref_urgent` change one edge after the stimulus that causes them. `ref_req` follows from the registered state and the live enable and self-refresh inputs in the same cycle. The bench drives inputs 2 ns after a rising edge. At each edge, a cycle model in the bench pushes its updated state into a queue. At the following falling edge, a monitor pops that entry and compares all three outputs. Directed checks sample at the drive point, after whole edges have been counted. For example, a settling wait of 5 means the request must still be low after the fourth edge and high after the fifth.

// File: rtl/refresh_acct_pkg.sv
package refresh_acct_pkg;

  localparam int unsigned BONUS_W = 2;

  // True when the running timer reaches the end of its period this cycle.
  function automatic logic tick_due(logic [31:0] cnt, logic [31:0] period);
    logic [31:0] eff;
    eff = (period == 32'd0) ? 32'd1 : period;
    return (cnt + 32'd1) >= eff;
  endfunction

  // Owed-count arithmetic: add, retire, then clamp at the ceiling.
  function automatic logic [31:0] owed_step(logic [31:0] cur, logic [31:0] add,
                                            logic [31:0] dec, logic [31:0] ceil);
    logic [31:0] s;
    s = cur + add - dec;
    return (s > ceil) ? ceil : s;
  endfunction

endpackage

// File: rtl/refresh_ivt.sv
module refresh_ivt #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [PERIOD_W-1:0] period,
  output logic                tick
);
  import refresh_acct_pkg::*;

  logic [PERIOD_W-1:0] cnt_q;

  assign tick = run & tick_due(32'(cnt_q), 32'(period));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= tick ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/refresh_owed.sv
module refresh_owed #(
  parameter int OWED_MAX  = 8,
  parameter int URGENT_AT = 6,
  parameter int CW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sr_active,
  input  logic          exit_evt,
  input  logic          acct_on,
  input  logic [1:0]    bonus,
  input  logic          tick,
  input  logic          ack_take,
  output logic [CW-1:0] owed,
  output logic          urgent
);
  import refresh_acct_pkg::*;

  logic [31:0] add_amt;
  logic [31:0] next_val;

  assign add_amt  = 32'(tick) + ((exit_evt & acct_on) ? 32'(bonus) : 32'd0);
  assign next_val = owed_step(32'(owed), add_amt, 32'(ack_take), 32'(OWED_MAX));
  assign urgent   = (32'(owed) >= 32'(URGENT_AT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         owed <= '0;
    else if (sr_active) owed <= '0;
    else                owed <= next_val[CW-1:0];
  end
endmodule

// File: rtl/refresh_exit_hold.sv
module refresh_exit_hold #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sr_active,
  input  logic [WAIT_W-1:0] wait_len,
  output logic              settled
);
  logic [WAIT_W-1:0] hold_q;

  assign settled = (hold_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hold_q <= '0;
    else if (sr_active)      hold_q <= wait_len;
    else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
  end
endmodule

// File: rtl/refresh_owed_ctrl.sv
module refresh_owed_ctrl #(
  parameter int PERIOD_W  = 16,
  parameter int WAIT_W    = 8,
  parameter int OWED_MAX  = 8,
  parameter int URGENT_AT = 6,
  localparam int CW       = $clog2(OWED_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_ref_en,
  input  logic                cfg_cnt_en,
  input  logic [PERIOD_W-1:0] cfg_period,
  input  logic [1:0]          cfg_exit_bonus,
  input  logic [WAIT_W-1:0]   cfg_exit_wait,
  input  logic                sr_active,
  input  logic                ref_ack,
  output logic                ref_req,
  output logic                ref_urgent,
  output logic [CW-1:0]       owed
);
  logic sr_q;
  logic exit_evt;
  logic acct_on;
  logic timer_run;
  logic tick;
  logic settled;
  logic ack_take;

  assign acct_on   = cfg_ref_en | cfg_cnt_en;
  assign timer_run = acct_on & ~sr_active;
  assign exit_evt  = sr_q & ~sr_active;
  assign ref_req   = cfg_ref_en & ~sr_active & settled & (owed != '0);
  assign ack_take  = ref_ack & ref_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 1'b0;
    else        sr_q <= sr_active;
  end

  refresh_ivt #(.PERIOD_W(PERIOD_W)) u_ivt (
    .clk(clk), .rst_n(rst_n), .run(timer_run), .period(cfg_period), .tick(tick)
  );

  refresh_owed #(.OWED_MAX(OWED_MAX), .URGENT_AT(URGENT_AT), .CW(CW)) u_owed (
    .clk(clk), .rst_n(rst_n), .sr_active(sr_active), .exit_evt(exit_evt),
    .acct_on(acct_on), .bonus(cfg_exit_bonus), .tick(tick), .ack_take(ack_take),
    .owed(owed), .urgent(ref_urgent)
  );

  refresh_exit_hold #(.WAIT_W(WAIT_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .sr_active(sr_active), .wait_len(cfg_exit_wait),
    .settled(settled)
  );
endmodule

// File: rtl/refresh_owed_chk.sv
module refresh_owed_chk #(
  parameter int WAIT_W   = 8,
  parameter int OWED_MAX = 8,
  parameter int CW       = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_ref_en,
  input logic              cfg_cnt_en,
  input logic [WAIT_W-1:0] cfg_exit_wait,
  input logic              sr_active,
  input logic              ref_req,
  input logic              ref_urgent,
  input logic [CW-1:0]     owed,
  input logic              tick,
  input logic              ack_take,
  input logic              exit_evt
);
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    32'(owed) <= 32'(OWED_MAX));

  a_r7_full_is_urgent: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(owed) == 32'(OWED_MAX)) |-> ref_urgent);

  a_r10_sr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sr_active |=> (owed == '0));

  a_r10_no_req_in_sr: assert property (@(posedge clk) disable iff (!rst_n)
    sr_active |-> !ref_req);

  a_r4_no_issue_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ref_en |-> !ref_req);

  a_r5_idle_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ref_en && !cfg_cnt_en) |-> !tick);

  a_r9_tick_ack_even: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ack_take && !exit_evt) |=> (owed == $past(owed)));

  a_r8_ack_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !tick && !exit_evt) |=> (owed == $past(owed) - 1'b1));

  a_r12_wait_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_evt && cfg_exit_wait != '0) |-> !ref_req);
endmodule

bind refresh_owed_ctrl refresh_owed_chk #(.WAIT_W(WAIT_W), .OWED_MAX(OWED_MAX), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_ref_en(cfg_ref_en), .cfg_cnt_en(cfg_cnt_en),
  .cfg_exit_wait(cfg_exit_wait), .sr_active(sr_active), .ref_req(ref_req),
  .ref_urgent(ref_urgent), .owed(owed), .tick(tick), .ack_take(ack_take),
  .exit_evt(exit_evt)
);

// File: tb/tb_refresh_owed_ctrl.sv
module tb_refresh_owed_ctrl;
  localparam int PW = 16;
  localparam int WW = 8;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          cfg_ref_en = 0, cfg_cnt_en = 0;
  logic [PW-1:0] cfg_period = 4;
  logic [1:0]    cfg_exit_bonus = 2'b10;
  logic [WW-1:0] cfg_exit_wait = 0;
  logic          sr_active = 0, ref_ack = 0;
  logic          ref_req, ref_urgent;
  logic [3:0]    owed;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  refresh_owed_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_ref_en(cfg_ref_en), .cfg_cnt_en(cfg_cnt_en),
    .cfg_period(cfg_period), .cfg_exit_bonus(cfg_exit_bonus),
    .cfg_exit_wait(cfg_exit_wait), .sr_active(sr_active), .ref_ack(ref_ack),
    .ref_req(ref_req), .ref_urgent(ref_urgent), .owed(owed)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model of the requirements, one state update per edge.
  typedef struct { int owed; int hold; } exp_t;
  exp_t sb_q[$];
  int m_owed = 0, m_t = 0, m_hold = 0, m_p = 1, m_v = 0;
  bit m_srq = 0, m_run = 0, m_tk = 0, m_req = 0, m_take = 0, m_ex = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_owed = 0; m_t = 0; m_hold = 0; m_srq = 0;
    end else begin
      m_p    = (cfg_period == 0) ? 1 : int'(cfg_period);
      m_run  = (cfg_ref_en || cfg_cnt_en) && !sr_active;
      m_tk   = m_run && (m_t + 1 >= m_p);
      m_req  = cfg_ref_en && !sr_active && m_hold == 0 && m_owed != 0;
      m_take = ref_ack && m_req;
      m_ex   = m_srq && !sr_active;
      if (m_run) m_t = m_tk ? 0 : m_t + 1;
      if (sr_active) m_owed = 0;
      else begin
        m_v = m_owed + int'(m_tk) - int'(m_take);
        if (m_ex && (cfg_ref_en || cfg_cnt_en)) m_v += int'(cfg_exit_bonus);
        m_owed = (m_v > 8) ? 8 : m_v;
      end
      if (sr_active) m_hold = int'(cfg_exit_wait);
      else if (m_hold > 0) m_hold--;
      m_srq = sr_active;
    end
    sb_q.push_back('{m_owed, m_hold});
  end

  // Monitor: compare each registered result half a cycle after its edge.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk("R2 owed", int'(owed), e.owed);
      chk("R7 urgent", int'(ref_urgent), int'(e.owed >= 6));
      chk("R3 req", int'(ref_req),
          int'(cfg_ref_en && !sr_active && e.hold == 0 && e.owed != 0));
    end
  end

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  initial begin
    cyc(2);
    chk("R1 owed", int'(owed), 0);
    chk("R1 req", int'(ref_req), 0);
    chk("R1 urgent", int'(ref_urgent), 0);
    rst_n = 1;

    cyc(20);
    chk("R5 idle owed", int'(owed), 0);

    cfg_cnt_en = 1; cfg_period = 4;
    cyc(12);
    chk("R2 three ticks", int'(owed), 3);
    chk("R4 no req", int'(ref_req), 0);

    cfg_cnt_en = 0; cyc(1);
    ref_ack = 1; cyc(1); ref_ack = 0; cyc(1);
    chk("R4 ack ignored", int'(owed), 3);
    chk("R8 stray ack", int'(owed), 3);

    cfg_cnt_en = 1; cyc(40);
    chk("R6 saturated", int'(owed), 8);
    chk("R7 urgent at 8", int'(ref_urgent), 1);

    cfg_cnt_en = 0; cfg_period = 1000; cfg_ref_en = 1; cyc(1);
    chk("R3 req with cnt off", int'(ref_req), 1);
    ref_ack = 1; cyc(1); ref_ack = 0;
    chk("R8 retire one", int'(owed), 7);
    ref_ack = 1; cyc(2); ref_ack = 0;
    chk("R8 retire two", int'(owed), 5);
    chk("R7 not urgent at 5", int'(ref_urgent), 0);

    cfg_period = 1; ref_ack = 1; cyc(3); ref_ack = 0;
    chk("R9 tick+ack even", int'(owed), 5);
    cyc(10);

    cfg_period = 1000; cfg_exit_bonus = 2'b11; cfg_exit_wait = 5;
    sr_active = 1; cyc(1);
    chk("R10 cleared", int'(owed), 0);
    chk("R10 no req", int'(ref_req), 0);
    cyc(10);
    chk("R10 held clear", int'(owed), 0);
    sr_active = 0; cyc(1);
    chk("R11 bonus 3", int'(owed), 3);
    chk("R12 wait req low", int'(ref_req), 0);
    cyc(3);
    chk("R12 wait edge 4", int'(ref_req), 0);
    cyc(1);
    chk("R12 wait done", int'(ref_req), 1);

    cfg_exit_wait = 0;
    for (int c = 0; c < 3; c++) begin
      cfg_exit_bonus = 2'(c);
      sr_active = 1; cyc(2);
      sr_active = 0; cyc(1);
      chk("R11 bonus code", int'(owed), c);
    end

    cfg_ref_en = 0; cfg_cnt_en = 0; cfg_exit_bonus = 2'b11;
    sr_active = 1; cyc(2); sr_active = 0; cyc(2);
    chk("R11 no bonus when idle", int'(owed), 0);

    cfg_cnt_en = 1; cfg_period = 0; cyc(5);
    chk("R2 period zero", int'(owed), 5);
    cyc(3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule